// File: doc/BRIEF.md
# Biphase Bit Integrator with Quality Flag

This block turns a stream of carrier-rate phase-sign samples into decoded data bits for a 1187.5 bit/s radio data link. Between two bit-boundary strobes it counts the samples. A sample counts as matching when it is positive in the first half of the bit or negative in the second half. The bit is decided as 1 when matching samples outnumber the others. The block also counts the positive samples over the whole bit. A biphase symbol that has not been disturbed has an even split (24 positive, 24 negative). When the split is lopsided, the bit is marked as unreliable.

A second decided-bit stream, produced by an alternative phase decoder outside this block, arrives on `alt_bit`. Each of the two bit streams passes through its own differential decoder. The data output takes either stream, selected by a control input. In automatic mode, a bad balance flag moves the data output to the alternate stream for that one bit. The quality output shows either the balance flag or the disagreement (XOR) of the two differential decoder outputs. Data, quality and a one-cycle valid strobe are all registered and update on the edge that samples the bit-boundary strobe.

Top module: `rbi_bit_integrator`

## Requirements
- R1: After synchronous reset `dat_o`, `qual_o` and `vld_o` are 0. The stored previous bit of both differential decoders is 0, so the first bit after reset is decoded against 0.
- R2: The polarity decision is 1 when the matching samples outnumber the non-matching ones. A matching sample is one with `smp_sign`=1 at sample index 0..23, or `smp_sign`=0 at index 24..47. When the two counts are equal the decision is 0.
- R3: The balance flag (1 = bad) is set when more than 40 samples of the bit are positive, or more than 40 are negative. Splits of exactly 40:8 and 8:40 are good.
- R4: The polarity-path differential output equals the current polarity decision XOR the previous polarity decision.
- R5: The alternate-path differential output equals `alt_bit` (sampled with `bit_stb`) XOR the previous sampled `alt_bit`.
- R6: With `auto_sel`=0, `dat_o` takes the polarity-path output when `src_sel`=0 and the alternate-path output when `src_sel`=1.
- R7: With `auto_sel`=1, `dat_o` takes the alternate-path output for a bit whose balance flag is bad, and the polarity-path output otherwise. `src_sel` is ignored in this mode.
- R8: `qual_o` shows the balance flag when `qual_sel`=0, and the XOR of the two differential outputs when `qual_sel`=1.
- R9: `dat_o`, `qual_o` and `vld_o` update on the clock edge that samples `bit_stb`=1. `vld_o` is high for exactly that one cycle per strobe. Between strobes `dat_o` and `qual_o` hold their values.
- R10: Samples after the 48th in a bit period are ignored. A sample whose strobe coincides with `bit_stb` is counted as sample index 0 of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Phase sample valid |
| smp_sign | input | 1 | Phase sign, 1 = positive relative to carrier |
| bit_stb | input | 1 | Bit boundary: closes the current bit period |
| alt_bit | input | 1 | Decided bit from the alternate decoder, sampled with `bit_stb` |
| src_sel | input | 1 | Manual data source: 0 polarity, 1 alternate |
| auto_sel | input | 1 | 1 = choose the data source from the balance flag |
| qual_sel | input | 1 | Quality source: 0 balance flag, 1 decoder disagreement |
| dat_o | output | 1 | Differentially decoded data bit |
| qual_o | output | 1 | Quality flag, 1 = suspect |
| vld_o | output | 1 | One-cycle strobe marking new `dat_o`/`qual_o` |

## Verification
The bench tests the balance limits from both sides: 40 and 41 positive samples, and 8 and 7. A design that used >= in the limit test, or that tested only one polarity, gets one of these four bits wrong. Tied matching counts must decide 0; a design that breaks ties toward 1 gives the wrong data bit. The bench sends extra samples past the 48th and a sample that coincides with the boundary. A design that keeps counting, or that drops or misfiles the coincident sample, shows the wrong quality flag. A reset in mid-stream must clear both stored previous bits. If either is left set, the first decoded bit after reset comes out inverted.

// File: rtl/rbi_pkg.sv
package rbi_pkg;
  // Per-bit result from the sample accumulator.
  typedef struct packed {
    logic dec;  // polarity decision
    logic bad;  // balance outside limits
  } rbi_verdict_t;

  typedef enum logic [0:0] {
    PATH_POL = 1'b0,
    PATH_ALT = 1'b1
  } rbi_path_e;
endpackage

// File: rtl/rbi_accum.sv
module rbi_accum
  import rbi_pkg::*;
#(
  parameter int SPB     = 48,
  parameter int BAD_LIM = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_stb,
  input  logic         smp_sign,
  input  logic         bit_stb,
  output rbi_verdict_t verdict
);
  localparam int CW   = $clog2(SPB + 1);
  localparam int HALF = SPB / 2;

  logic [CW-1:0] idx_q;   // samples taken this period
  logic [CW-1:0] pos_q;   // positive samples
  logic [CW-1:0] agr_q;   // samples matching a 1 symbol
  logic [CW-1:0] neg_w;
  logic          match_w;

  always_comb begin
    neg_w       = idx_q - pos_q;
    verdict.dec = ({agr_q, 1'b0} > {1'b0, idx_q});
    verdict.bad = (pos_q > CW'(BAD_LIM)) || (neg_w > CW'(BAD_LIM));
    match_w     = (idx_q < CW'(HALF)) ? smp_sign : ~smp_sign;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      pos_q <= '0;
      agr_q <= '0;
    end else if (bit_stb) begin
      // coincident sample opens the new period as index 0
      idx_q <= CW'(smp_stb);
      pos_q <= CW'(smp_stb & smp_sign);
      agr_q <= CW'(smp_stb & smp_sign);
    end else if (smp_stb && (idx_q < CW'(SPB))) begin
      idx_q <= idx_q + 1'b1;
      pos_q <= pos_q + CW'(smp_sign);
      agr_q <= agr_q + CW'(match_w);
    end
  end

  p_idx_bound_r10: assert property (@(posedge clk) disable iff (rst)
    idx_q <= CW'(SPB));
  p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !bit_stb && idx_q == CW'(SPB)) |=> (idx_q == CW'(SPB)) && $stable(pos_q));
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> idx_q == CW'($past(smp_stb)));
endmodule

// File: rtl/rbi_diff.sv
module rbi_diff (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic din,
  output logic dout
);
  logic prev_q;

  assign dout = din ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst)      prev_q <= 1'b0;
    else if (stb) prev_q <= din;
  end

  p_prev_load_r4: assert property (@(posedge clk) disable iff (rst)
    stb |=> prev_q == $past(din));
  p_prev_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(prev_q));
endmodule

// File: rtl/rbi_select.sv
module rbi_select
  import rbi_pkg::*;
(
  input  logic pol_d,
  input  logic alt_d,
  input  logic bad,
  input  logic src_sel,
  input  logic auto_sel,
  input  logic qual_sel,
  output logic dat_n,
  output logic qual_n
);
  rbi_path_e path;

  always_comb begin
    if (auto_sel) path = bad ? PATH_ALT : PATH_POL;
    else          path = src_sel ? PATH_ALT : PATH_POL;
    dat_n  = (path == PATH_ALT) ? alt_d : pol_d;
    qual_n = qual_sel ? (pol_d ^ alt_d) : bad;
  end
endmodule

// File: rtl/rbi_bit_integrator.sv
module rbi_bit_integrator
  import rbi_pkg::*;
#(
  parameter int SPB     = 48,
  parameter int BAD_LIM = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_stb,
  input  logic smp_sign,
  input  logic bit_stb,
  input  logic alt_bit,
  input  logic src_sel,
  input  logic auto_sel,
  input  logic qual_sel,
  output logic dat_o,
  output logic qual_o,
  output logic vld_o
);
  localparam int NPATH = 2;

  rbi_verdict_t     verdict;
  logic [NPATH-1:0] path_din;
  logic [NPATH-1:0] path_dout;
  logic             dat_n;
  logic             qual_n;

  rbi_accum #(.SPB(SPB), .BAD_LIM(BAD_LIM)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .smp_sign (smp_sign),
    .bit_stb  (bit_stb),
    .verdict  (verdict)
  );

  assign path_din[PATH_POL] = verdict.dec;
  assign path_din[PATH_ALT] = alt_bit;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    rbi_diff u_diff (
      .clk  (clk),
      .rst  (rst),
      .stb  (bit_stb),
      .din  (path_din[g]),
      .dout (path_dout[g])
    );
  end

  rbi_select u_sel (
    .pol_d    (path_dout[PATH_POL]),
    .alt_d    (path_dout[PATH_ALT]),
    .bad      (verdict.bad),
    .src_sel  (src_sel),
    .auto_sel (auto_sel),
    .qual_sel (qual_sel),
    .dat_n    (dat_n),
    .qual_n   (qual_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_o  <= 1'b0;
      qual_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= bit_stb;
      if (bit_stb) begin
        dat_o  <= dat_n;
        qual_o <= qual_n;
      end
    end
  end

  p_vld_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> vld_o);
  p_vld_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> !vld_o);
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(dat_o) && $stable(qual_o));
  p_auto_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && auto_sel) |=>
      dat_o == ($past(verdict.bad) ? $past(path_dout[PATH_ALT]) : $past(path_dout[PATH_POL])));
  p_qual_xor_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && qual_sel) |=>
      qual_o == ($past(path_dout[PATH_POL]) ^ $past(path_dout[PATH_ALT])));
endmodule

// File: tb/rbi_bit_integrator_bench.sv
module rbi_bit_integrator_bench;
  logic clk = 1'b0;
  logic rst, smp_stb, smp_sign, bit_stb, alt_bit, src_sel, auto_sel, qual_sel;
  logic dat_o, qual_o, vld_o;
  int   checks = 0;
  int   fails  = 0;
  int   cycles = 0;

  always #4 clk = ~clk;

  rbi_bit_integrator u_rbi_bit_integrator (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_sign(smp_sign),
    .bit_stb(bit_stb), .alt_bit(alt_bit), .src_sel(src_sel),
    .auto_sel(auto_sel), .qual_sel(qual_sel),
    .dat_o(dat_o), .qual_o(qual_o), .vld_o(vld_o)
  );

  // {p1 positives in first half, p2 positives in second half,
  //  alt, src, auto, qsel, expected dat, expected qual}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {6'd24, 6'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 R4 R5 R6
    {6'd0,  6'd24, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 R8
    {6'd24, 6'd24, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 tie, R3 48 pos, R7
    {6'd20, 6'd20, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 40 good, R7
    {6'd21, 6'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 41 bad
    {6'd4,  6'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 8 good
    {6'd4,  6'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 7 bad, R7 R8
    {6'd13, 6'd11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 R6
    {6'd12, 6'd13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R2 R8
    {6'd24, 6'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}   // R7 good path
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic samples(input int npos, input int ntot);
    for (int i = 0; i < ntot; i++) begin
      @(negedge clk);
      smp_stb  = 1'b1;
      smp_sign = (i < npos);
    end
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic half_bits(input int p1, input int p2);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      smp_stb  = 1'b1;
      smp_sign = (i < 24) ? (i < p1) : ((i - 24) < p2);
    end
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // strobe, optionally with a coincident positive sample; checks after edge
  task automatic strobe(input logic with_smp);
    bit_stb  = 1'b1;
    smp_stb  = with_smp;
    smp_sign = with_smp;
    @(negedge clk);
    bit_stb = 1'b0;
    smp_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; smp_stb = 0; smp_sign = 0; bit_stb = 0; alt_bit = 0;
    src_sel = 0; auto_sel = 0; qual_sel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dat", dat_o, 1'b0);
    chk("R1 qual", qual_o, 1'b0);
    chk("R1 vld", vld_o, 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [17:0] e;
      e = VEC[v];
      alt_bit = e[5]; src_sel = e[4]; auto_sel = e[3]; qual_sel = e[2];
      half_bits(int'(e[17:12]), int'(e[11:6]));
      strobe(1'b0);
      chk("R9 vld", vld_o, 1'b1);
      chk("R2-R8 vector dat", dat_o, e[1]);
      chk("R3 R8 vector qual", qual_o, e[0]);
      @(negedge clk);
      // R9 one-cycle valid and hold
      chk("R9 vld drop", vld_o, 1'b0);
      chk("R9 dat hold", dat_o, e[1]);
      chk("R9 qual hold", qual_o, e[0]);
    end

    // R1: prev bits left at 1,1 by the table; reset must clear both
    do_reset();
    chk("R1 dat after reset", dat_o, 1'b0);
    alt_bit = 1'b0; src_sel = 1'b0; auto_sel = 1'b0; qual_sel = 1'b1;
    half_bits(0, 24);                  // decision 0
    strobe(1'b0);
    chk("R1 pol prev cleared", dat_o, 1'b0);
    chk("R1 both prev cleared", qual_o, 1'b0);

    // R10: extra samples past 48 are ignored
    do_reset();
    qual_sel = 1'b0;
    half_bits(24, 0);                  // 24 positive so far
    samples(20, 20);                   // would reach 44 positive
    strobe(1'b0);
    chk("R10 extras ignored qual", qual_o, 1'b0);
    chk("R10 extras ignored dat", dat_o, 1'b1);

    // R10: coincident sample belongs to the new period
    do_reset();
    qual_sel = 1'b0;
    half_bits(24, 0);
    strobe(1'b1);                      // positive sample with the strobe
    chk("R10 prior period qual", qual_o, 1'b0);
    samples(40, 47);                   // 40 + 1 coincident = 41 positive
    strobe(1'b0);
    chk("R10 coincident counted qual", qual_o, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule